// File: doc/BRIEF.md
# Battery Hibernate and Soft-Off Inactivity Timer

This block sits next to a platform power sequencer and keeps two clocks running from a 1 µs tick. The first measures how long the platform stays in soft-off with nothing happening. It asks the sequencer to fall back to the fully-off state once a fixed number of quiet seconds has passed. The second measures how long the platform stays fully off while running from its battery. It raises a single hibernate request once a programmable delay in seconds has been exceeded. A hibernate request carries no timed wake; only an external wake event ends it.

The sequencer reports its state on a two-bit input and the supply reports whether AC is present. The hibernate countdown starts again when the off state is entered, and also whenever AC goes away while the platform is off. A plugged-in supply holds the request back indefinitely. Software may rewrite the delay at any time, and the seconds still to go can be read while off on battery. A wake event seen in the off state cancels the pending request until the off state is entered again.

Top module: `hib_idle_timer`

## Requirements
- R1: After reset the delay holds HIB_DEFAULT_S, the hibernate countdown behaves as if the off state had just been entered, and both request outputs are low.
- R2: In soft-off (seq_state = 2'b01), softoff_timeout is high for one cycle at the clock edge that takes the SOFTOFF_S*TICKS_PER_SEC-th tick since the count last restarted. The count then restarts.
- R3: An activity pulse, or any cycle outside soft-off, restarts the soft-off count. No timeout is raised in that cycle, and none is raised outside soft-off.
- R4: Elapsed seconds advance once every TICKS_PER_SEC ticks since the countdown restarted. secs_left equals the delay minus the elapsed seconds, saturating at 0. secs_left_valid is high exactly when seq_state = 2'b00 (off) and ac_present is low.
- R5: When the platform is off on battery, hib_req is high for one cycle at the edge that takes the first tick arriving while the elapsed seconds are at least the delay. A delay of 0 therefore fires on the first tick. Only one pulse is produced per arming.
- R6: While ac_present is high, hib_req stays low no matter how long the platform has been off.
- R7: The countdown restarts, from zero elapsed time, when seq_state changes into off. It also restarts when ac_present falls while the platform is off.
- R8: A delay write (delay_we with delay_wdata) takes effect from the next cycle. It also applies to a countdown already in progress.
- R9: A wake pulse in the off state cancels the pending request. Later AC removal does not re-arm it; only the next entry to off does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| seq_state | input | 2 | Sequencer state: 00 off, 01 soft-off, 10/11 other |
| ac_present | input | 1 | External supply present |
| activity | input | 1 | Soft-off activity or power-up request pulse |
| delay_we | input | 1 | Hibernate delay write strobe |
| delay_wdata | input | SECS_W | New hibernate delay in seconds |
| wake | input | 1 | Wake request pulse |
| softoff_timeout | output | 1 | Request to drop from soft-off to off (pulse) |
| hib_req | output | 1 | Hibernate request (pulse) |
| secs_left | output | SECS_W | Seconds remaining before hibernate |
| secs_left_valid | output | 1 | secs_left is meaningful (off on battery) |

## Verification
The hibernate path is first run straight from reset, and the pulse must land exactly one tick past the delay. A second run spends a long stretch on AC and then unplugs. Firing on the first battery tick would show the timestamp was not retaken at AC removal. The delay is then rewritten in mid-count, set to zero, and followed by a wake. These runs separate a live delay compare from a latched one, show the zero-delay boundary, and show that AC removal alone does not re-arm a cancelled request. The soft-off path is driven with an uninterrupted quiet period and with an activity pulse. It is also driven with an excursion out of soft-off and with the other state. Together these show whether the count restarts and whether the timeout is confined to soft-off.

// File: rtl/hib_idle_timer.sv
module hib_idle_timer #(
  parameter int TICKS_PER_SEC = 1000000,
  parameter int SOFTOFF_S     = 10,
  parameter int HIB_DEFAULT_S = 86400,
  parameter int SECS_W        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic [1:0]        seq_state,
  input  logic              ac_present,
  input  logic              activity,
  input  logic              delay_we,
  input  logic [SECS_W-1:0] delay_wdata,
  input  logic              wake,
  output logic              softoff_timeout,
  output logic              hib_req,
  output logic [SECS_W-1:0] secs_left,
  output logic              secs_left_valid
);
  localparam int SUB_W      = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int SOFT_LIMIT = SOFTOFF_S * TICKS_PER_SEC;
  localparam int SOFT_W     = $clog2(SOFT_LIMIT + 1);
  localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(TICKS_PER_SEC - 1);
  localparam logic [SOFT_W-1:0] SOFT_LAST = SOFT_W'(SOFT_LIMIT - 1);
  localparam logic [1:0] ST_OFF  = 2'b00;
  localparam logic [1:0] ST_SOFT = 2'b01;

  logic              prev_off_q, prev_ac_q, armed_q;
  logic [SUB_W-1:0]  sub_q;
  logic [SECS_W-1:0] elapsed_q, delay_q;
  logic [SOFT_W-1:0] soft_cnt_q;

  wire in_off    = (seq_state == ST_OFF);
  wire in_soft   = (seq_state == ST_SOFT);
  wire off_entry = in_off & ~prev_off_q;
  wire ac_drop   = in_off & prev_ac_q & ~ac_present;
  wire restamp   = off_entry | ac_drop;
  wire sec_wrap  = tick_us & (sub_q == SUB_LAST);
  wire past_due  = (elapsed_q >= delay_q);
  wire fire      = in_off & ~ac_present & armed_q & tick_us & past_due & ~wake & ~restamp;

  assign secs_left       = past_due ? '0 : (delay_q - elapsed_q);
  assign secs_left_valid = in_off & ~ac_present;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_off_q <= 1'b1;
      prev_ac_q  <= 1'b0;
      armed_q    <= 1'b1;
      sub_q      <= '0;
      elapsed_q  <= '0;
      delay_q    <= SECS_W'(HIB_DEFAULT_S);
      hib_req    <= 1'b0;
    end else begin
      prev_off_q <= in_off;
      prev_ac_q  <= ac_present;
      hib_req    <= fire;
      if (delay_we) delay_q <= delay_wdata;
      if (restamp) begin
        sub_q     <= '0;
        elapsed_q <= '0;
      end else if (tick_us) begin
        sub_q <= sec_wrap ? '0 : sub_q + 1'b1;
        if (sec_wrap && elapsed_q != '1) elapsed_q <= elapsed_q + 1'b1;
      end
      if (off_entry)              armed_q <= 1'b1;
      else if (in_off && wake)    armed_q <= 1'b0;
      else if (fire)              armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_cnt_q      <= '0;
      softoff_timeout <= 1'b0;
    end else begin
      softoff_timeout <= in_soft & ~activity & tick_us & (soft_cnt_q == SOFT_LAST);
      if (!in_soft || activity)  soft_cnt_q <= '0;
      else if (tick_us)          soft_cnt_q <= (soft_cnt_q == SOFT_LAST) ? '0 : soft_cnt_q + 1'b1;
    end
  end

  p_timeout_soft_r2: assert property (@(posedge clk) disable iff (!rst_n)
    softoff_timeout |-> ($past(seq_state) == ST_SOFT));
  p_activity_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !softoff_timeout);
  p_left_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    secs_left <= delay_q);
  p_hib_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hib_req |=> !hib_req);
  p_hib_battery_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hib_req |-> !$past(ac_present));
  p_wake_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && in_off) |=> !hib_req);
endmodule

// File: tb/tb_hib_idle_timer.sv
module tb_hib_idle_timer;
  localparam int TPS = 4, SOFT = 3, HIBD = 6, W = 32;

  logic clk = 0, rst_n = 0, tick_us = 0, ac_present = 0, activity = 0;
  logic delay_we = 0, wake = 0;
  logic [1:0] seq_state = 2'b00;
  logic [W-1:0] delay_wdata = '0;
  logic softoff_timeout, hib_req, secs_left_valid;
  logic [W-1:0] secs_left;
  int checks = 0, failures = 0;
  bit done = 0;

  hib_idle_timer #(.TICKS_PER_SEC(TPS), .SOFTOFF_S(SOFT), .HIB_DEFAULT_S(HIBD), .SECS_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .seq_state(seq_state),
    .ac_present(ac_present), .activity(activity), .delay_we(delay_we),
    .delay_wdata(delay_wdata), .wake(wake), .softoff_timeout(softoff_timeout),
    .hib_req(hib_req), .secs_left(secs_left), .secs_left_valid(secs_left_valid));

  always #2 clk = ~clk;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic tick_once(); @(negedge clk) tick_us = 1; @(negedge clk) tick_us = 0; endtask
  task automatic ticks_quiet(int n, string req);
    for (int i = 0; i < n; i++) begin
      tick_once();
      chk(req, {31'd0, hib_req | softoff_timeout}, 0);
    end
  endtask
  task automatic set_state(logic [1:0] s); @(negedge clk) seq_state = s; @(negedge clk); endtask
  task automatic enter_off(); set_state(2'b10); set_state(2'b00); endtask
  task automatic write_delay(int d);
    @(negedge clk) begin delay_we = 1; delay_wdata = W'(d); end
    @(negedge clk) delay_we = 0;
  endtask

  task automatic t_reset_and_countdown();
    chk("R1 hib_req", {31'd0, hib_req}, 0);
    chk("R1 timeout", {31'd0, softoff_timeout}, 0);
    chk("R1 secs_left", secs_left, HIBD);
    chk("R4 valid off battery", {31'd0, secs_left_valid}, 1);
    ticks_quiet(4, "R5 early");
    chk("R4 one second", secs_left, HIBD - 1);
    ticks_quiet(19, "R5 early");
    chk("R4 23 ticks", secs_left, 1);
    ticks_quiet(1, "R5 at delay");
    chk("R4 zero", secs_left, 0);
    tick_once();
    chk("R5 fire", {31'd0, hib_req}, 1);
    step();
    chk("R5 one cycle", {31'd0, hib_req}, 0);
    ticks_quiet(8, "R5 single pulse");
    chk("R4 saturate", secs_left, 0);
  endtask

  task automatic t_ac_hold();
    set_state(2'b10);
    ac_present = 1;
    set_state(2'b00);
    chk("R4 valid on AC", {31'd0, secs_left_valid}, 0);
    ticks_quiet(40, "R6 AC holds");
    @(negedge clk) ac_present = 0;
    @(negedge clk);
    chk("R7 restamp on AC drop", secs_left, HIBD);
    ticks_quiet(24, "R7 no early fire");
    tick_once();
    chk("R7 fire after drop", {31'd0, hib_req}, 1);
  endtask

  task automatic t_delay_write();
    enter_off();
    chk("R7 restamp on entry", secs_left, HIBD);
    write_delay(2);
    chk("R8 new delay", secs_left, 2);
    ticks_quiet(4, "R8 early");
    chk("R8 counting", secs_left, 1);
    write_delay(3);
    chk("R8 mid-count raise", secs_left, 2);
    ticks_quiet(8, "R8 early");
    tick_once();
    chk("R8 fire at new delay", {31'd0, hib_req}, 1);
    enter_off();
    write_delay(0);
    chk("R5 zero delay left", secs_left, 0);
    chk("R5 zero no tick", {31'd0, hib_req}, 0);
    tick_once();
    chk("R5 zero delay fire", {31'd0, hib_req}, 1);
  endtask

  task automatic t_wake();
    write_delay(1);
    enter_off();
    ticks_quiet(2, "R9 before wake");
    @(negedge clk) wake = 1;
    @(negedge clk) wake = 0;
    ticks_quiet(20, "R9 cancelled");
    @(negedge clk) ac_present = 1;
    @(negedge clk) ac_present = 0;
    ticks_quiet(10, "R9 AC drop no rearm");
    enter_off();
    ticks_quiet(4, "R9 rearmed early");
    tick_once();
    chk("R9 rearmed fire", {31'd0, hib_req}, 1);
  endtask

  task automatic t_softoff();
    set_state(2'b01);
    chk("R4 valid soft", {31'd0, secs_left_valid}, 0);
    ticks_quiet(11, "R2 early");
    tick_once();
    chk("R2 timeout", {31'd0, softoff_timeout}, 1);
    step();
    chk("R2 one cycle", {31'd0, softoff_timeout}, 0);
    ticks_quiet(11, "R2 restart");
    tick_once();
    chk("R2 second timeout", {31'd0, softoff_timeout}, 1);
    ticks_quiet(10, "R3 before activity");
    @(negedge clk) activity = 1;
    @(negedge clk) activity = 0;
    ticks_quiet(11, "R3 after activity");
    tick_once();
    chk("R3 timeout after activity", {31'd0, softoff_timeout}, 1);
    ticks_quiet(8, "R3 before leave");
    set_state(2'b10);
    set_state(2'b01);
    ticks_quiet(11, "R3 after excursion");
    tick_once();
    chk("R3 timeout after excursion", {31'd0, softoff_timeout}, 1);
    set_state(2'b11);
    ticks_quiet(20, "R3 other state");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_and_countdown();
    t_ac_hold();
    t_delay_write();
    t_wake();
    t_softoff();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule